// File: doc/BRIEF.md
# Power-Up Strap Latch and Pin-Role Controller

This block manages two dual-use pads on a clock-generator die. While the chip comes out of reset, both pads are inputs whose levels (configuration straps) choose the spread-spectrum modulation type. Once those levels have been captured and confirmed, the pads change role: pad 0 becomes the crystal-drive output and pad 1 becomes a buffered reference-clock output running at the input-clock frequency. The captured strap bits go to the modulation logic and cannot change until the next reset.

After reset is released, the controller waits a fixed settle interval with every dual-use pad driver off. It then takes two consecutive synchronized samples of the straps. It latches them only when the two samples agree, and otherwise retries. A done flag marks the moment the pads switch to their output roles. A global output-enable input, passed through a two-flop synchronizer, gates all pad drivers: when it is low, every output is tri-stated. A test input, also synchronized, asks the modulation logic to bypass spreading and multiplication. An unconnected strap pad reads as logic one because of its internal pull-up, so the strap synchronizer resets to ones. All interfaces are plain level signals, so there is no valid/ready handshake and no back-pressure.

Top module: `strap_pin_ctrl`

## Requirements
- R1: While reset is held, `main_oe`, both bits of `strap_pad_oe` and `strap_done` are 0, `strap_cfg` is 2'b11 and `mod_bypass` is 0.
- R2: Neither bit of `strap_pad_oe` is 1 while `strap_done` is 0, whatever `oe_pin` does.
- R3: With the straps held steady, `strap_done` becomes 1 after exactly SETTLE_CYC+2 rising clock edges following reset release, and is 0 after SETTLE_CYC+1 edges.
- R4: `strap_cfg` takes the value of the two synchronized samples only when they are equal (bit 0 from pad 0, bit 1 from pad 1). If the straps change on every cycle, no latch occurs and `strap_done` stays 0. Once the straps settle, the latch follows within 8 cycles.
- R5: After `strap_done` is 1, it stays 1 and `strap_cfg` holds its value until the next reset, whatever `strap_pin` does.
- R6: `main_oe` equals the level `oe_pin` had two rising edges earlier (two-flop synchronizer), and 0 means the outputs are tri-stated.
- R7: Each bit of `strap_pad_oe` is 1 exactly when `strap_done` is 1 and the synchronized output enable (that is, `main_oe`) is 1.
- R8: `mod_bypass` equals the inverse of the level `test_pin_n` had two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pin | input | 2 | Pad input levels of the two dual-use pads (bit 0 crystal pad, bit 1 reference pad) |
| oe_pin | input | 1 | Global output enable, asynchronous; low tri-states all outputs |
| test_pin_n | input | 1 | Active-low test request, asynchronous |
| main_oe | output | 1 | Driver enable for the main modulated clock output |
| strap_pad_oe | output | 2 | Driver enables for the dual-use pads in their output roles |
| strap_cfg | output | 2 | Latched spread-type strap bits |
| strap_done | output | 1 | Straps latched and dual-use pads in their output roles |
| mod_bypass | output | 1 | Synchronized request to bypass spreading and multiplication |

## Verification
The enable and test outputs are due two rising edges after a change on `oe_pin` or `test_pin_n`. `strap_done` and `strap_cfg` are due SETTLE_CYC+2 edges after reset release. The bench drives inputs on falling edges and advances a two-stage shadow pipeline on each rising edge. It compares the outputs at the next falling edge against that pipeline and against an edge count kept since reset. For the retry case it checks that `strap_done` stays low while the straps toggle, then checks the latch a fixed eight cycles after they settle. That is a bound and not an exact cycle.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned NUM_STRAP = 2;

  typedef enum logic [1:0] {
    PH_SETTLE   = 2'd0,
    PH_SAMPLE_A = 2'd1,
    PH_SAMPLE_B = 2'd2,
    PH_HOLD     = 2'd3
  } phase_t;

  typedef logic [NUM_STRAP-1:0] strap_vec_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W       = 1,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R3
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int unsigned W = NUM_STRAP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expire,
  input  logic [W-1:0] strap_s,
  output logic         run,
  output logic [W-1:0] cfg,
  output logic         done
);
  phase_t       phase;
  logic [W-1:0] samp_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_SETTLE;
      samp_a <= '1;
      cfg    <= '1;
      done   <= 1'b0;
    end else begin
      unique case (phase)
        PH_SETTLE: begin
          if (expire) phase <= PH_SAMPLE_A;
        end
        PH_SAMPLE_A: begin
          samp_a <= strap_s;
          phase  <= PH_SAMPLE_B;
        end
        PH_SAMPLE_B: begin
          if (strap_s == samp_a) begin
            cfg   <= strap_s;
            done  <= 1'b1;
            phase <= PH_HOLD;
          end else begin
            phase <= PH_SAMPLE_A;
          end
        end
        default: phase <= PH_HOLD;
      endcase
    end
  end

  assign run = (phase == PH_SETTLE);

  AST_NO_DONE_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE) |-> !done); // R3
  AST_LATCH_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cfg == $past(strap_s))); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> (done && $stable(cfg))); // R5
endmodule

// File: rtl/pin_role_ctl.sv
module pin_role_ctl #(
  parameter int unsigned W = 2
) (
  input  logic         done,
  input  logic         oe_s,
  output logic         main_oe,
  output logic [W-1:0] pad_oe
);
  assign main_oe = oe_s;

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pad_oe[i] = done & oe_s;
  end
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_STRAP-1:0] strap_pin,
  input  logic                 oe_pin,
  input  logic                 test_pin_n,
  output logic                 main_oe,
  output logic [NUM_STRAP-1:0] strap_pad_oe,
  output logic [NUM_STRAP-1:0] strap_cfg,
  output logic                 strap_done,
  output logic                 mod_bypass
);
  strap_vec_t strap_s;
  logic       oe_s;
  logic       test_s;
  logic       run;
  logic       expire;

  bit_sync #(.W(NUM_STRAP), .RST_VAL(1'b1)) u_strap_sync (
    .clk(clk), .rst_n(rst_n), .d(strap_pin), .q(strap_s));
  bit_sync #(.W(1), .RST_VAL(1'b0)) u_oe_sync (
    .clk(clk), .rst_n(rst_n), .d(oe_pin), .q(oe_s));
  bit_sync #(.W(1), .RST_VAL(1'b1)) u_test_sync (
    .clk(clk), .rst_n(rst_n), .d(test_pin_n), .q(test_s));

  settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .expire(expire));

  strap_capture #(.W(NUM_STRAP)) u_capture (
    .clk(clk), .rst_n(rst_n), .expire(expire), .strap_s(strap_s),
    .run(run), .cfg(strap_cfg), .done(strap_done));

  pin_role_ctl #(.W(NUM_STRAP)) u_roles (
    .done(strap_done), .oe_s(oe_s), .main_oe(main_oe), .pad_oe(strap_pad_oe));

  assign mod_bypass = ~test_s;

  AST_MAIN_OE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    main_oe |-> $past(oe_pin, 2)); // R6
  AST_BYPASS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    mod_bypass |-> !$past(test_pin_n, 2)); // R8
endmodule

// File: tb/tb_strap_pin_ctrl.sv
module tb_strap_pin_ctrl;
  localparam int unsigned SETTLE = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_pin = 2'b11;
  logic       oe_pin = 1'b0;
  logic       test_pin_n = 1'b1;
  logic       main_oe, strap_done, mod_bypass;
  logic [1:0] strap_pad_oe, strap_cfg;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  logic oe1, oe2, tn1, tn2;
  logic [1:0] exp_cfg;

  always #5 clk = ~clk;

  strap_pin_ctrl #(.SETTLE_CYC(SETTLE)) dut (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h edge=%0d", req, act, exp, edges);
    end
  endtask

  function automatic logic exp_done_f(int e);
    return e >= SETTLE + 2;
  endfunction

  task automatic step(input logic oe, input logic tn, input logic [1:0] sp);
    oe_pin = oe; test_pin_n = tn; strap_pin = sp;
    @(posedge clk);
    edges++;
    oe2 = oe1; oe1 = oe; tn2 = tn1; tn1 = tn;
    @(negedge clk);
  endtask

  task automatic check_outputs(input logic done_exp);
    chk("R6", {3'b0, main_oe}, {3'b0, oe2});
    chk("R8", {3'b0, mod_bypass}, {3'b0, ~tn2});
    chk("R7", {2'b0, strap_pad_oe}, {2'b0, {2{done_exp & oe2}}});
    if (!strap_done) chk("R2", {2'b0, strap_pad_oe}, 4'h0);
  endtask

  task automatic do_reset(input logic [1:0] sp);
    rst_n = 1'b0; strap_pin = sp; oe_pin = 1'b1; test_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {main_oe, strap_pad_oe, strap_done}, 4'h0);
    chk("R1", {1'b0, mod_bypass, strap_cfg}, 4'h3);
    rst_n = 1'b1;
    edges = 0; oe1 = 0; oe2 = 0; tn1 = 1; tn2 = 1;
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    // Directed: settle timing for each strap value
    for (int v = 0; v < 4; v++) begin
      do_reset(v[1:0]);
      while (edges < SETTLE + 1) begin
        step(edges[2], 1'b1, v[1:0]);
        check_outputs(1'b0);
      end
      chk("R3", {3'b0, strap_done}, 4'h0);
      step(1'b1, 1'b1, v[1:0]);
      chk("R3", {3'b0, strap_done}, {3'b0, exp_done_f(edges)});
      chk("R4", {2'b0, strap_cfg}, {2'b0, v[1:0]});
      exp_cfg = v[1:0];
      // Random traffic after latch
      for (int k = 0; k < 150; k++) begin
        step(1'($urandom), 1'($urandom), 2'($urandom));
        check_outputs(1'b1);
        chk("R5", {1'b0, strap_done, strap_cfg}, {2'b01, exp_cfg});
      end
    end
    // Retry: straps toggle every cycle, so samples never agree
    do_reset(2'b01);
    for (int k = 0; k < SETTLE + 40; k++) begin
      step(1'b1, 1'b1, k[0] ? 2'b10 : 2'b01);
      check_outputs(1'b0);
    end
    chk("R4", {3'b0, strap_done}, 4'h0);
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 2'b10);
    chk("R4", {1'b0, strap_done, strap_cfg}, 4'h6);
    chk("R8", {3'b0, mod_bypass}, 4'h1);
    chk("R7", {2'b0, strap_pad_oe}, 4'h3);
    // Output enable low tri-states everything
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 2'b00);
      check_outputs(1'b1);
    end
    chk("R6", {main_oe, strap_pad_oe, 1'b0}, 4'h0);
    chk("R5", {1'b0, strap_done, strap_cfg}, 4'h6);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule